// File: doc/BRIEF.md
# Ethernet PHY link supervisor

This block brings up and watches one external Ethernet PHY through clause-22 style management register accesses, with no software in the loop. It checks for a PHY, reads its status register, and then either forces a speed and duplex or advertises the PHY's abilities and lets the PHY negotiate. When the PHY negotiates, the block reads the partner's abilities and picks the best mode that both sides support. Once the link is up it polls the status register at a fixed interval. A dropped link makes it restart negotiation and configure the PHY again.

Management traffic goes to an external MDIO master through a request/acknowledge port. Each request carries the PHY address, a 5-bit register address, a write flag and 16-bit write data. The master pulses acknowledge for one cycle and, for a read, presents the read data in that same cycle. Time is counted in ticks of a prescaler. The poll interval and the link timeout are tick counts, so the defaults give about 900 ms and 3 s at 100 MHz.

The supervisor runs only while auto-select is set, software override is clear and the PHY address is valid. At any other time it stays quiet and leaves the PHY to software.

Top module: `phy_link_sup`

## Requirements
- R1: While `auto_sel_i` is 0, or `sw_ovr_i` is 1, or `phy_addr_vld_i` is 0, no request is issued and all four status outputs are 0. Any transfer in progress is abandoned and the block waits in idle.
- R2: Each request carries the PHY address that was sampled when the supervisor started, on `mdio_phy_o`. No request is made before `phy_addr_vld_i` is 1.
- R3: A status read that returns 16'hFFFF or 16'h0000 means no PHY is present. In that case no write is made, and the status read is tried again once per poll interval.
- R4: After it becomes active, the first access the supervisor makes is a read of register 1 (status).
- R5: The supervisor uses forced mode when status bit 3 (negotiation ability) is 0 or when `adv_an_i` is 0. In forced mode it writes register 0 with bit 13 = `force_100_i`, bit 8 = `force_fd_i` and every other bit 0. When a later status read shows bit 2 (link) set, it reports the forced speed and duplex. Status bit 5 is not needed in this mode.
- R6: Otherwise the supervisor writes register 4 and then writes register 0 = 16'h1200 (negotiation enable and restart). The register 4 value is 16'h0001 with the local abilities copied from status bits 15 (T4), 14 (100X full), 13 (100X half), 12 (10T full) and 11 (10T half) into bits 9, 8, 7, 6 and 5 in that order.
- R7: In negotiated mode the link counts as up when status bits 2 and 5 are both set. The supervisor then reads register 5, whose bits 9..5 use the layout of R6, and ANDs it with the local abilities. It picks the first common mode in the order 100X full, T4, 100X half, 10T full, 10T half. `speed_100_o` is 1 for the first three. `full_dup_o` is 1 for 100X full and 10T full.
- R8: If no mode is common to both sides, `link_fail_o` goes to 1 and `link_up_o` stays 0. `link_up_o` and `link_fail_o` are never 1 together.
- R9: `link_fail_o` rises when the link is not seen within LINK_TO_TICKS ticks of the control register write. After that the status register is re-read once per poll interval. `link_fail_o` clears when the link comes up.
- R10: While the link is up, the status register is read once every POLL_TICKS ticks.
- R11: If a poll finds the link down, `link_up_o`, `speed_100_o` and `full_dup_o` clear. In negotiated mode the next access is a write of register 0 = 16'h1200, and the access after that is a status read.
- R12: While the supervisor is active, `mdio_req_o` and its fields hold steady until `mdio_ack_i`. `mdio_req_o` is low in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_sel_i | input | 1 | Enables automatic port management |
| sw_ovr_i | input | 1 | Software takes over control of the PHY |
| adv_an_i | input | 1 | Allows auto-negotiation when the PHY supports it |
| force_fd_i | input | 1 | Forced-mode full duplex |
| force_100_i | input | 1 | Forced-mode 100 Mb/s |
| phy_addr_i | input | 5 | PHY address |
| phy_addr_vld_i | input | 1 | PHY address is valid |
| mdio_req_o | output | 1 | Management request |
| mdio_we_o | output | 1 | Request is a write |
| mdio_phy_o | output | 5 | PHY address of the request |
| mdio_reg_o | output | 5 | Register address |
| mdio_wdata_o | output | 16 | Write data |
| mdio_ack_i | input | 1 | One-cycle acknowledge from the master |
| mdio_rdata_i | input | 16 | Read data, valid while acknowledge is high |
| link_up_o | output | 1 | Link is up |
| speed_100_o | output | 1 | Resolved speed is 100 Mb/s |
| full_dup_o | output | 1 | Resolved duplex is full |
| link_fail_o | output | 1 | Link failed or no common mode |

## Verification
The bench builds the block with TICK_DIV=4, POLL_TICKS=8 and LINK_TO_TICKS=20. With these values the poll interval is about 32 cycles and the link timeout about 80 cycles, so the bench can measure both windows directly. They also make a full bring-up short enough to sweep all 32×32 pairs of local and partner abilities, checking both the resolved mode and the advertisement word for each pair. A behavioural PHY answers every request, so the bench can also cover the absent-PHY retry, every combination of the forced bits, a timeout followed by recovery, and a link drop followed by renegotiation.

// File: rtl/phy_sup_pkg.sv
package phy_sup_pkg;
  localparam int ABL_W = 5;  // [4]100X-FD [3]T4 [2]100X-HD [1]10T-FD [0]10T-HD
  localparam logic [4:0] REG_CTRL = 5'd0;
  localparam logic [4:0] REG_STAT = 5'd1;
  localparam logic [4:0] REG_ADV  = 5'd4;
  localparam logic [4:0] REG_LPA  = 5'd5;
  localparam logic [15:0] CTRL_AN_RESTART = 16'h1200;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_STAT, ST_ABSENT, ST_WR_ADV, ST_WR_AN, ST_WR_FRC,
    ST_CHK, ST_RD_LPA, ST_UP, ST_POLL, ST_RESTART, ST_FAILW
  } sup_st_e;

  function automatic logic [ABL_W-1:0] stat_to_abl(input logic [15:0] s);
    return {s[14], s[15], s[13], s[12], s[11]};
  endfunction

  function automatic logic [ABL_W-1:0] lpa_to_abl(input logic [15:0] l);
    return {l[8], l[9], l[7], l[6], l[5]};
  endfunction

  function automatic logic [15:0] abl_to_adv(input logic [ABL_W-1:0] a);
    logic [15:0] w;
    w = 16'h0001;
    w[8] = a[4];
    w[9] = a[3];
    w[7] = a[2];
    w[6] = a[1];
    w[5] = a[0];
    return w;
  endfunction
endpackage

// File: rtl/phy_sup_prescale.sv
module phy_sup_prescale #(
  parameter int DIV = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/phy_sup_interval.sv
module phy_sup_interval #(
  parameter int LIMIT = 900
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM);

  p_clr_restarts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !done_o);
endmodule

// File: rtl/phy_sup_resolve.sv
module phy_sup_resolve
  import phy_sup_pkg::*;
(
  input  logic [ABL_W-1:0] common_i,
  output logic             hit_o,
  output logic             spd100_o,
  output logic             fdx_o
);
  logic [ABL_W-1:0] sel;

  // first set bit from the top wins
  for (genvar i = 0; i < ABL_W; i++) begin : g_pri
    if (i == ABL_W - 1) begin : g_top
      assign sel[i] = common_i[i];
    end else begin : g_low
      assign sel[i] = common_i[i] & ~(|common_i[ABL_W-1:i+1]);
    end
  end

  assign hit_o    = |sel;
  assign spd100_o = sel[4] | sel[3] | sel[2];
  assign fdx_o    = sel[4] | sel[1];
endmodule

// File: rtl/phy_sup_fsm.sv
module phy_sup_fsm
  import phy_sup_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             adv_an_i,
  input  logic             force_fd_i,
  input  logic             force_100_i,
  input  logic [4:0]       phy_addr_i,
  input  logic             poll_done_i,
  input  logic             to_done_i,
  input  logic             res_hit_i,
  input  logic             res_spd_i,
  input  logic             res_fd_i,
  output logic [ABL_W-1:0] common_o,
  output logic             poll_clr_o,
  output logic             to_clr_o,
  output logic             mdio_req_o,
  output logic             mdio_we_o,
  output logic [4:0]       mdio_phy_o,
  output logic [4:0]       mdio_reg_o,
  output logic [15:0]      mdio_wdata_o,
  input  logic             mdio_ack_i,
  input  logic [15:0]      mdio_rdata_i,
  output logic             link_up_o,
  output logic             speed_100_o,
  output logic             full_dup_o,
  output logic             link_fail_o
);
  sup_st_e state_q, state_d;
  logic up_q, up_d, fail_q, fail_d, spd_q, spd_d, fd_q, fd_d;
  logic an_q, an_d, fs_q, fs_d, ff_q, ff_d, gap_q;
  logic [ABL_W-1:0] abl_q, abl_d;
  logic [4:0] addr_q, addr_d;
  logic req_state, xfer, link_ok, absent;

  always_comb begin
    req_state    = 1'b1;
    mdio_we_o    = 1'b0;
    mdio_reg_o   = REG_STAT;
    mdio_wdata_o = '0;
    unique case (state_q)
      ST_RD_STAT, ST_CHK, ST_POLL: ;
      ST_RD_LPA: mdio_reg_o = REG_LPA;
      ST_WR_ADV: begin
        mdio_we_o    = 1'b1;
        mdio_reg_o   = REG_ADV;
        mdio_wdata_o = abl_to_adv(abl_q);
      end
      ST_WR_AN, ST_RESTART: begin
        mdio_we_o    = 1'b1;
        mdio_reg_o   = REG_CTRL;
        mdio_wdata_o = CTRL_AN_RESTART;
      end
      ST_WR_FRC: begin
        mdio_we_o        = 1'b1;
        mdio_reg_o       = REG_CTRL;
        mdio_wdata_o[13] = force_100_i;
        mdio_wdata_o[8]  = force_fd_i;
      end
      default: req_state = 1'b0;
    endcase
  end

  assign mdio_req_o = req_state && !gap_q;
  assign mdio_phy_o = addr_q;
  assign xfer       = mdio_req_o && mdio_ack_i;
  assign link_ok    = mdio_rdata_i[2] && (!an_q || mdio_rdata_i[5]);
  assign absent     = (mdio_rdata_i == 16'hFFFF) || (mdio_rdata_i == 16'h0000);
  assign common_o   = abl_q & lpa_to_abl(mdio_rdata_i);

  always_comb begin
    state_d = state_q;
    up_d = up_q; fail_d = fail_q; spd_d = spd_q; fd_d = fd_q;
    an_d = an_q; fs_d = fs_q; ff_d = ff_q; abl_d = abl_q; addr_d = addr_q;
    if (!en_i) begin
      state_d = ST_IDLE;
      up_d = 1'b0; fail_d = 1'b0; spd_d = 1'b0; fd_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          addr_d  = phy_addr_i;
          state_d = ST_RD_STAT;
        end
        ST_RD_STAT: if (xfer) begin
          if (absent) state_d = ST_ABSENT;
          else begin
            abl_d   = stat_to_abl(mdio_rdata_i);
            an_d    = mdio_rdata_i[3] && adv_an_i;
            state_d = (mdio_rdata_i[3] && adv_an_i) ? ST_WR_ADV : ST_WR_FRC;
          end
        end
        ST_ABSENT: if (poll_done_i) state_d = ST_RD_STAT;
        ST_WR_ADV: if (xfer) state_d = ST_WR_AN;
        ST_WR_AN:  if (xfer) state_d = ST_CHK;
        ST_WR_FRC: if (xfer) begin
          fs_d    = force_100_i;
          ff_d    = force_fd_i;
          state_d = ST_CHK;
        end
        ST_CHK: if (xfer) begin
          if (link_ok) begin
            if (an_q) state_d = ST_RD_LPA;
            else begin
              up_d = 1'b1; fail_d = 1'b0; spd_d = fs_q; fd_d = ff_q;
              state_d = ST_UP;
            end
          end else if (to_done_i) begin
            fail_d  = 1'b1;
            state_d = ST_FAILW;
          end
        end
        ST_RD_LPA: if (xfer) begin
          if (res_hit_i) begin
            up_d = 1'b1; fail_d = 1'b0; spd_d = res_spd_i; fd_d = res_fd_i;
            state_d = ST_UP;
          end else begin
            fail_d  = 1'b1;
            state_d = ST_FAILW;
          end
        end
        ST_UP: if (poll_done_i) state_d = ST_POLL;
        ST_POLL: if (xfer) begin
          if (link_ok) state_d = ST_UP;
          else begin
            up_d = 1'b0; spd_d = 1'b0; fd_d = 1'b0;
            state_d = an_q ? ST_RESTART : ST_RD_STAT;
          end
        end
        ST_RESTART: if (xfer) state_d = ST_RD_STAT;
        ST_FAILW:   if (poll_done_i) state_d = ST_CHK;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  assign poll_clr_o = (state_d != state_q);
  assign to_clr_o   = xfer && (state_q == ST_WR_AN || state_q == ST_WR_FRC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      up_q <= 1'b0; fail_q <= 1'b0; spd_q <= 1'b0; fd_q <= 1'b0;
      an_q <= 1'b0; fs_q <= 1'b0; ff_q <= 1'b0; gap_q <= 1'b0;
      abl_q <= '0; addr_q <= '0;
    end else begin
      state_q <= state_d;
      up_q <= up_d; fail_q <= fail_d; spd_q <= spd_d; fd_q <= fd_d;
      an_q <= an_d; fs_q <= fs_d; ff_q <= ff_d; gap_q <= xfer;
      abl_q <= abl_d; addr_q <= addr_d;
    end
  end

  assign link_up_o   = up_q;
  assign speed_100_o = spd_q;
  assign full_dup_o  = fd_q;
  assign link_fail_o = fail_q;

  p_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!mdio_req_o && !link_up_o && !link_fail_o));
  p_up_after_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_up_o) |-> $past(mdio_ack_i));
  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_up_o && link_fail_o));
  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_req_o && !mdio_ack_i && en_i) |=> mdio_req_o);
  p_fields_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_req_o && !mdio_ack_i && en_i) |=>
      ($stable(mdio_reg_o) && $stable(mdio_we_o) && $stable(mdio_phy_o)));
  p_gap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_ack_i |=> !mdio_req_o);
endmodule

// File: rtl/phy_link_sup.sv
module phy_link_sup
  import phy_sup_pkg::*;
#(
  parameter int TICK_DIV      = 100000,
  parameter int POLL_TICKS    = 900,
  parameter int LINK_TO_TICKS = 3000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        auto_sel_i,
  input  logic        sw_ovr_i,
  input  logic        adv_an_i,
  input  logic        force_fd_i,
  input  logic        force_100_i,
  input  logic [4:0]  phy_addr_i,
  input  logic        phy_addr_vld_i,
  output logic        mdio_req_o,
  output logic        mdio_we_o,
  output logic [4:0]  mdio_phy_o,
  output logic [4:0]  mdio_reg_o,
  output logic [15:0] mdio_wdata_o,
  input  logic        mdio_ack_i,
  input  logic [15:0] mdio_rdata_i,
  output logic        link_up_o,
  output logic        speed_100_o,
  output logic        full_dup_o,
  output logic        link_fail_o
);
  logic en, tick, poll_clr, poll_done, to_clr, to_done;
  logic res_hit, res_spd, res_fd;
  logic [ABL_W-1:0] common;

  assign en = auto_sel_i && !sw_ovr_i && phy_addr_vld_i;

  phy_sup_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  phy_sup_interval #(.LIMIT(POLL_TICKS)) u_poll (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(poll_clr), .tick_i(tick), .done_o(poll_done)
  );

  phy_sup_interval #(.LIMIT(LINK_TO_TICKS)) u_tmo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(to_clr), .tick_i(tick), .done_o(to_done)
  );

  phy_sup_resolve u_res (
    .common_i(common), .hit_o(res_hit), .spd100_o(res_spd), .fdx_o(res_fd)
  );

  phy_sup_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .adv_an_i(adv_an_i), .force_fd_i(force_fd_i), .force_100_i(force_100_i),
    .phy_addr_i(phy_addr_i),
    .poll_done_i(poll_done), .to_done_i(to_done),
    .res_hit_i(res_hit), .res_spd_i(res_spd), .res_fd_i(res_fd),
    .common_o(common), .poll_clr_o(poll_clr), .to_clr_o(to_clr),
    .mdio_req_o(mdio_req_o), .mdio_we_o(mdio_we_o), .mdio_phy_o(mdio_phy_o),
    .mdio_reg_o(mdio_reg_o), .mdio_wdata_o(mdio_wdata_o),
    .mdio_ack_i(mdio_ack_i), .mdio_rdata_i(mdio_rdata_i),
    .link_up_o(link_up_o), .speed_100_o(speed_100_o),
    .full_dup_o(full_dup_o), .link_fail_o(link_fail_o)
  );
endmodule

// File: tb/phy_link_sup_test.sv
module phy_link_sup_test;
  localparam int D = 4, P = 8, L = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic auto_sel = 1'b1, sw_ovr = 1'b0, adv_an = 1'b1, f_fd = 1'b0, f_100 = 1'b0;
  logic [4:0] paddr = 5'h11;
  logic pvld = 1'b0;
  logic req, we, ack, up, spd, fd, fail;
  logic [4:0] phy, rg;
  logic [15:0] wdata, rdata;

  always #5 clk = ~clk;

  phy_link_sup #(.TICK_DIV(D), .POLL_TICKS(P), .LINK_TO_TICKS(L)) uut (
    .clk_i(clk), .rst_ni(rst_n), .auto_sel_i(auto_sel), .sw_ovr_i(sw_ovr),
    .adv_an_i(adv_an), .force_fd_i(f_fd), .force_100_i(f_100),
    .phy_addr_i(paddr), .phy_addr_vld_i(pvld),
    .mdio_req_o(req), .mdio_we_o(we), .mdio_phy_o(phy), .mdio_reg_o(rg),
    .mdio_wdata_o(wdata), .mdio_ack_i(ack), .mdio_rdata_i(rdata),
    .link_up_o(up), .speed_100_o(spd), .full_dup_o(fd), .link_fail_o(fail)
  );

  // PHY model state
  logic m_present = 1'b0, m_an = 1'b1, m_link = 1'b0, m_ancomp = 1'b0;
  logic [4:0] m_abl = 5'h1f, m_lpa = 5'h1f;
  logic [1:0] lat;
  logic got_first, arm = 1'b0;
  logic [5:0] first_acc;
  logic [15:0] last_ctrl, last_adv;
  logic [21:0] cap0, cap1;
  int cyc = 0, ctrl_cnt, adv_cnt, stat_cnt, stat_cyc, stat_iv, ctrl_cyc, addr_err, perr, rise_cnt, ncap;
  logic p_req, p_ack, p_en, p_we;
  logic [4:0] p_rg;
  int n_vec = 0, n_err = 0;

  wire [15:0] stat_w = m_present ?
    {m_abl[3], m_abl[4], m_abl[2], m_abl[1], m_abl[0], 5'b0, m_ancomp, 1'b0, m_an, m_link, 2'b01}
    : 16'hFFFF;
  wire [15:0] lpa_w = {6'b0, m_lpa[3], m_lpa[4], m_lpa[2], m_lpa[1], m_lpa[0], 5'b00001};
  wire en_now = auto_sel && !sw_ovr && pvld;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 0; lat <= 0; rdata <= 0; got_first <= 0; first_acc <= 0;
      last_ctrl <= 0; last_adv <= 0; ctrl_cnt <= 0; adv_cnt <= 0; stat_cnt <= 0;
      stat_cyc <= 0; stat_iv <= 0; ctrl_cyc <= 0; addr_err <= 0; ncap <= 0;
      cap0 <= 0; cap1 <= 0;
    end else if (ack) ack <= 1'b0;
    else if (req) begin
      if (lat == 2'd2) begin
        ack <= 1'b1; lat <= 0;
        if (phy != paddr) addr_err <= addr_err + 1;
        if (!got_first) begin got_first <= 1'b1; first_acc <= {we, rg}; end
        if (arm && ncap == 0) begin cap0 <= {we, rg, wdata}; ncap <= 1; end
        if (arm && ncap == 1) begin cap1 <= {we, rg, wdata}; ncap <= 2; end
        if (we) begin
          if (rg == 5'd0) begin last_ctrl <= wdata; ctrl_cnt <= ctrl_cnt + 1; ctrl_cyc <= cyc; end
          if (rg == 5'd4) begin last_adv <= wdata; adv_cnt <= adv_cnt + 1; end
        end else begin
          rdata <= (rg == 5'd1) ? stat_w : (rg == 5'd5) ? lpa_w : 16'h0;
          if (rg == 5'd1) begin
            stat_cnt <= stat_cnt + 1; stat_iv <= cyc - stat_cyc; stat_cyc <= cyc;
          end
        end
      end else lat <= lat + 1'b1;
    end else lat <= 0;
  end

  // handshake monitor (R12) and request counter
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_req <= 0; p_ack <= 0; p_en <= 0; p_we <= 0; p_rg <= 0; perr <= 0; rise_cnt <= 0;
    end else begin
      p_req <= req; p_ack <= ack; p_en <= en_now; p_we <= we; p_rg <= rg;
      if (p_req && !p_ack && p_en && (!req || we != p_we || rg != p_rg)) perr <= perr + 1;
      if (p_ack && req) perr <= perr + 1;
      if (req && !p_req) rise_cnt <= rise_cnt + 1;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_res(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (up || fail) break;
    end
  endtask

  task automatic rerun;
    sw_ovr = 1'b1; cycles(3); sw_ovr = 1'b0;
  endtask

  function automatic logic [3:0] exp_res(input logic [4:0] c);
    if (c[4]) return 4'b1011;
    else if (c[3]) return 4'b1010;
    else if (c[2]) return 4'b1010;
    else if (c[1]) return 4'b1001;
    else if (c[0]) return 4'b1000;
    else return 4'b0100;
  endfunction

  initial begin : main
    int t0, n0, r0, a0;
    cycles(3); rst_n = 1'b1; cycles(1);
    chk("R1 reset outputs", {req, up, spd, fd, fail}, 5'b0);
    cycles(60);
    chk("R2 no request before address valid", rise_cnt, 0);
    pvld = 1'b1;
    // absent PHY
    cycles(120);
    chk("R4 first access read of reg 1", first_acc, 6'b000001);
    chk("R3 absent: no writes", ctrl_cnt + adv_cnt, 0);
    chk("R3 absent: status retried", stat_cnt >= 3, 1);
    chk("R3 absent: link down", {up, fail}, 2'b00);
    // PHY appears, full abilities
    m_present = 1'b1; m_link = 1'b1; m_ancomp = 1'b1;
    wait_res(200);
    chk("R7 full abilities resolve 100X-FD", {up, fail, spd, fd}, 4'b1011);
    chk("R6 advertisement word", last_adv, 16'h03E1);
    // poll interval
    n0 = stat_cnt;
    while (stat_cnt < n0 + 3) @(negedge clk);
    chk("R10 poll interval in range", (stat_iv >= (P-1)*D) && (stat_iv <= P*D + 10), 1);
    // link drop
    m_link = 1'b0;
    for (int i = 0; i < 100 && up; i++) @(negedge clk);
    arm = 1'b1;
    chk("R11 drop clears status", {up, spd, fd}, 3'b000);
    while (ncap < 2) @(negedge clk);
    arm = 1'b0;
    chk("R11 restart write after drop", cap0, {1'b1, 5'd0, 16'h1200});
    chk("R11 status read after restart", cap1[21:16], 6'b000001);
    m_link = 1'b1;
    wait_res(300);
    chk("R11 relink after drop", {up, fail}, 2'b10);
    // disable paths
    auto_sel = 1'b0; cycles(2);
    chk("R1 auto-select off clears", {req, up, spd, fd, fail}, 5'b0);
    r0 = rise_cnt; cycles(60);
    chk("R1 auto-select off: no traffic", rise_cnt - r0, 0);
    auto_sel = 1'b1; sw_ovr = 1'b1; cycles(2);
    r0 = rise_cnt; cycles(60);
    chk("R1 override: no traffic", {rise_cnt - r0, up}, 0);
    sw_ovr = 1'b0;
    // negotiated sweep
    for (int lo = 0; lo < 32; lo++)
      for (int pa = 0; pa < 32; pa++) begin
        m_abl = lo[4:0]; m_lpa = pa[4:0]; m_link = 1'b1; m_ancomp = 1'b1; m_an = 1'b1;
        rerun(); wait_res(300);
        chk("R7 R8 resolved mode", {up, fail, spd, fd}, exp_res(m_abl & m_lpa));
        chk("R6 advertisement and control",
            {last_adv, last_ctrl},
            {6'b0, m_abl[3], m_abl[4], m_abl[2], m_abl[1], m_abl[0], 5'b00001, 16'h1200});
      end
    // forced sweep
    m_abl = 5'h1f; m_ancomp = 1'b0;
    for (int k = 0; k < 12; k++) begin
      m_an = (k / 4 == 1); adv_an = (k / 4 == 2) ? 1'b1 : 1'b0;
      if (k / 4 == 2) m_an = 1'b0;
      f_100 = k[1]; f_fd = k[0];
      a0 = adv_cnt;
      rerun(); wait_res(300);
      chk("R5 forced result", {up, fail, spd, fd}, {2'b10, f_100, f_fd});
      chk("R5 forced control word", last_ctrl, {2'b0, f_100, 4'b0, f_fd, 8'b0});
      chk("R5 no advertisement write", adv_cnt - a0, 0);
    end
    // timeout
    m_an = 1'b0; m_link = 1'b0; f_100 = 1'b1; f_fd = 1'b0;
    rerun();
    for (int i = 0; i < 400 && !fail; i++) @(negedge clk);
    t0 = cyc - ctrl_cyc;
    chk("R9 timeout window", (t0 >= (L-1)*D) && (t0 <= L*D + 12), 1);
    chk("R8 fail without link up", {up, fail}, 2'b01);
    m_link = 1'b1;
    for (int i = 0; i < 100 && !up; i++) @(negedge clk);
    chk("R9 recovery clears fail", {up, fail, spd}, 3'b101);
    chk("R2 address on every access", addr_err, 0);
    chk("R12 handshake protocol", perr, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec + 1, n_err);
    $finish;
  end
endmodule